// File: doc/BRIEF.md
# Programmable Sinc Decimator for One-Bit Streams

This block turns a one-bit oversampled stream, taken once per system clock, into multi-bit samples. The density of ones in the stream stands for the measured level. A chain of running-sum stages accumulates the stream every clock. Once per programmable decimation period, a chain of differencing stages takes the result and forms one output sample. The filter order is selectable between second and third order. All arithmetic is 27 bits wide and wraps modulo 2^27. The legal period therefore depends on the order: third order allows up to 511 clocks, second order up to 11585 clocks, so the full-scale result N^k always fits in the word.

A restart input clears all filter state. Changing the order or the effective period restarts the filter in the same way. After any restart, the block raises a strobe for every completed period. It keeps its valid flag low until the filter history is fully built from the new stream. The first decimation is treated as contaminated and discarded. Order-plus-one strobes must pass before valid rises.

Top module: `cic_decim`

## Requirements
- R1: After a restart, every clock edge with `start` low and an unchanged configuration accepts one bit. `strobe` is high for exactly the one cycle that follows the edge accepting bit number P, 2P, 3P, ..., where P is the effective period, and it is low at all other times.
- R2: Let k be the order. The sample presented with a strobe after bit n equals the k-fold boxcar sum of the accepted bits: the stream convolved k times with a length-P window of ones, evaluated at bit n. Bits before the restart count as zero.
- R3: With a constant stream and the filter settled, the sample is 0 for all zeros and P^k for all ones. For the alternating stream 1,0,1,0,... with even P, the sample is P^k/2.
- R4: `order3` = 1 selects third order (k = 3). `order3` = 0 selects second order (k = 2). With the same all-ones stream and P = 16, the settled sample is 4096 and 256 respectively.
- R5: `period_req` is an unsigned count of clocks. The effective period is 1 when the request is 0. It is 511 when the request exceeds 511 in third order, and 11585 when the request exceeds 11585 in second order. Otherwise it is the request.
- R6: `valid` is low after a restart. It rises together with strobe number k+1 after that restart and stays high until the next restart.
- R7: When `start` is high at a clock edge, the edge discards the bit, clears all filter history, and drives `strobe` and `valid` low. Samples after the restart do not depend on bits accepted before it.
- R8: A change of `order3`, or of the effective period, seen at a clock edge acts as a restart at that edge.
- R9: Integrators wrap modulo 2^27. `sample` is exact even when the internal sums have wrapped many times, up to the maximum legal period.
- R10: While `rst_n` is low, and until the first edge after its synchronous release, `sample`, `strobe` and `valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one stream bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous restart of the filter |
| bit_in | input | 1 | Modulator stream bit |
| order3 | input | 1 | 1 = third order, 0 = second order |
| period_req | input | 14 | Requested decimation period in clocks |
| sample | output | 27 | Most recent decimated sample, held between strobes |
| strobe | output | 1 | One-cycle pulse when a new sample is presented |
| valid | output | 1 | High once the filter has settled since the last restart |

## Verification
The bench targets the edges of the settling sequence and the configuration handling.

- It checks that `valid` rises on exactly the k+1-th strobe. A design that counted settling from the wrong strobe would raise `valid` one window early or late.
- It runs all-ones streams at the maximum period of each order and with oversized requests. A design that clamped wrongly, or lost the modular wrap of the internal sums, would miss the exact N^k result.
- It runs an all-zeros stream right after an all-ones run. Any history left behind by a restart would show as a nonzero sample.
- It changes the order or the period without asserting `start`. A design that ignored such a change would keep `valid` high and return a sample mixed from two periods.
- It compares random densities at random short periods against a weighted-window sum. This catches a skipped or misaligned difference stage.

// File: rtl/cic_decim_pkg.sv
package cic_decim_pkg;
  localparam int CIC_W      = 27;
  localparam int CIC_PW     = 14;
  localparam int CIC_MAX3   = 511;
  localparam int CIC_MAX2   = 11585;
  localparam int CIC_STAGES = 3;

  // Effective period for a request, shared by the design defaults and the checker.
  function automatic logic [CIC_PW-1:0] cic_clamp(input logic o3, input logic [CIC_PW-1:0] req);
    logic [CIC_PW-1:0] lim;
    lim = o3 ? CIC_PW'(CIC_MAX3) : CIC_PW'(CIC_MAX2);
    if (req == '0) return CIC_PW'(1);
    if (req > lim) return lim;
    return req;
  endfunction
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl #(
  parameter int PW   = 14,
  parameter int MAX3 = 511,
  parameter int MAX2 = 11585
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          order3,
  input  logic [PW-1:0] period_req,
  output logic          clr,
  output logic          tick,
  output logic          cfg_o3,
  output logic          strobe,
  output logic          valid
);
  localparam logic [PW-1:0] LIM3 = PW'(MAX3);
  localparam logic [PW-1:0] LIM2 = PW'(MAX2);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic [PW-1:0] per_eff, per_q, per_d, cnt_q, cnt_d;
  logic          o3_q, o3_d, val_d, stb_d;
  logic [2:0]    set_q, set_d, set_inc;

  always_comb begin
    per_eff = period_req;
    if (period_req == '0)                  per_eff = ONE;
    else if (order3 && period_req > LIM3)  per_eff = LIM3;
    else if (!order3 && period_req > LIM2) per_eff = LIM2;

    clr     = start || (order3 != o3_q) || (per_eff != per_q);
    tick    = !clr && (cnt_q == per_q - ONE);
    set_inc = set_q + 3'd1;

    per_d = per_q;
    o3_d  = o3_q;
    cnt_d = cnt_q;
    set_d = set_q;
    val_d = valid;
    stb_d = 1'b0;
    if (clr) begin
      per_d = per_eff;
      o3_d  = order3;
      cnt_d = '0;
      set_d = '0;
      val_d = 1'b0;
    end else begin
      cnt_d = tick ? '0 : cnt_q + ONE;
      stb_d = tick;
      if (tick && !valid) begin
        set_d = set_inc;
        val_d = (set_inc == (o3_q ? 3'd4 : 3'd3));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      o3_q   <= 1'b0;
      cnt_q  <= '0;
      set_q  <= '0;
      valid  <= 1'b0;
      strobe <= 1'b0;
    end else begin
      per_q  <= per_d;
      o3_q   <= o3_d;
      cnt_q  <= cnt_d;
      set_q  <= set_d;
      valid  <= val_d;
      strobe <= stb_d;
    end
  end

  assign cfg_o3 = o3_q;
endmodule

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int W      = 27,
  parameter int STAGES = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                bit_in,
  output logic [W*STAGES-1:0] taps
);
  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic [W-1:0] acc_q, add_in, nxt;
    if (s == 0) begin : g_first
      assign add_in = {{(W-1){1'b0}}, bit_in};
    end else begin : g_rest
      assign add_in = g_st[s-1].nxt;
    end

    always_comb nxt = acc_q + add_in;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (clr) acc_q <= '0;
      else          acc_q <= nxt;
    end

    assign taps[s*W +: W] = nxt;
  end
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
  parameter int W      = 27,
  parameter int STAGES = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic [W-1:0]        x,
  output logic [W*STAGES-1:0] diffs
);
  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic [W-1:0] z_q, din, d;
    if (s == 0) begin : g_first
      assign din = x;
    end else begin : g_rest
      assign din = g_st[s-1].d;
    end

    always_comb d = din - z_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   z_q <= '0;
      else if (clr) z_q <= '0;
      else if (en)  z_q <= din;
    end

    assign diffs[s*W +: W] = d;
  end
endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_decim_pkg::*;
#(
  parameter int W    = CIC_W,
  parameter int PW   = CIC_PW,
  parameter int MAX3 = CIC_MAX3,
  parameter int MAX2 = CIC_MAX2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bit_in,
  input  logic          order3,
  input  logic [PW-1:0] period_req,
  output logic [W-1:0]  sample,
  output logic          strobe,
  output logic          valid
);
  localparam int STAGES = CIC_STAGES;

  logic [1:0]            rs_q;
  logic                  rst_i, clr, tick, cfg_o3;
  logic [W*STAGES-1:0]   taps, diffs;
  logic [1:0]            tap;
  logic [W-1:0]          x, res;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  cic_ctrl #(.PW(PW), .MAX3(MAX3), .MAX2(MAX2)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .start(start), .order3(order3),
    .period_req(period_req), .clr(clr), .tick(tick), .cfg_o3(cfg_o3),
    .strobe(strobe), .valid(valid)
  );

  cic_integ #(.W(W), .STAGES(STAGES)) u_integ (
    .clk(clk), .rst_n(rst_i), .clr(clr), .bit_in(bit_in), .taps(taps)
  );

  assign tap = cfg_o3 ? 2'd2 : 2'd1;
  assign x   = taps[tap*W +: W];

  cic_comb #(.W(W), .STAGES(STAGES)) u_comb (
    .clk(clk), .rst_n(rst_i), .clr(clr), .en(tick), .x(x), .diffs(diffs)
  );

  assign res = diffs[tap*W +: W];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)    sample <= '0;
    else if (tick) sample <= res;
  end
endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk
  import cic_decim_pkg::*;
#(
  parameter int W  = CIC_W,
  parameter int PW = CIC_PW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          order3,
  input logic [PW-1:0] period_req,
  input logic [W-1:0]  sample,
  input logic          strobe,
  input logic          valid
);
  logic          prev_o3;
  logic [PW-1:0] prev_req;
  logic [63:0]   p64, fs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_o3  <= 1'b0;
      prev_req <= '0;
    end else begin
      prev_o3  <= order3;
      prev_req <= period_req;
    end
  end

  always_comb begin
    p64 = 64'(cic_clamp(prev_o3, CIC_PW'(prev_req)));
    fs  = prev_o3 ? p64 * p64 * p64 : p64 * p64;
  end

  a_r3_full_scale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> ({{(64-W){1'b0}}, sample} <= fs));

  a_r2_sample_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> $stable(sample));

  a_r6_valid_rises_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> strobe);

  a_r6_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start && order3 == prev_o3 && period_req == prev_req) |=> valid);

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!valid && !strobe));

  a_r8_order_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (order3 != prev_o3) |=> (!valid && !strobe));
endmodule

bind cic_decim cic_decim_chk #(.W(W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .order3(order3),
  .period_req(period_req), .sample(sample), .strobe(strobe), .valid(valid)
);

// File: tb/cic_decim_test.sv
`timescale 1ns/1ps
module cic_decim_test;
  localparam int W  = 27;
  localparam int PW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          bit_in = 1'b0;
  logic          order3 = 1'b0;
  logic [PW-1:0] period_req = '0;
  logic [W-1:0]  sample;
  logic          strobe, valid;

  always #5 clk = ~clk;

  cic_decim uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_in(bit_in), .order3(order3),
    .period_req(period_req), .sample(sample), .strobe(strobe), .valid(valid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int hist [0:1023];
  int wts  [0:255];
  int wlen;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_period(input bit o3, input int req);
    int lim;
    lim = o3 ? 511 : 11585;
    if (req == 0) return 1;
    return (req > lim) ? lim : req;
  endfunction

  // k-fold convolution of a length-p window of ones.
  task automatic build_w(input int k, input int p);
    int nw [0:255];
    for (int j = 0; j < p; j++) wts[j] = 1;
    wlen = p;
    for (int r = 1; r < k; r++) begin
      for (int j = 0; j < wlen + p - 1; j++) begin
        nw[j] = 0;
        for (int i = 0; i < p; i++)
          if (j - i >= 0 && j - i < wlen) nw[j] += wts[j - i];
      end
      wlen = wlen + p - 1;
      for (int j = 0; j < wlen; j++) wts[j] = nw[j];
    end
  endtask

  function automatic longint model(input int n);
    longint s;
    s = 0;
    for (int j = 0; j < wlen; j++)
      if (n - j >= 1) s += longint'(hist[n - j]) * wts[j];
    return s;
  endfunction

  // pat: 0 zeros, 1 ones, 2 alternating, 3 random with density dens percent
  task automatic run(input bit o3, input int req, input int pat, input int nwin,
                     input bit via_start, input int dens, input string tag);
    int p, k, n, seen, nb;
    longint full, ex;
    bit es;
    p = eff_period(o3, req);
    k = o3 ? 3 : 2;
    full = (k == 3) ? longint'(p) * p * p : longint'(p) * p;
    if (pat == 3) build_w(k, p);
    @(negedge clk);
    order3 = o3;
    period_req = PW'(req);
    start = via_start;
    bit_in = 1'b0;
    n = 0;
    seen = 0;
    repeat (nwin * p + 1) begin
      @(negedge clk);
      es = (n > 0) && (n % p == 0);
      if (n == 0)
        chk(!strobe && !valid, via_start ? "R7 restart clears flags" : "R8 config change clears flags",
            {strobe, valid}, 0);
      chk(strobe == es, "R1 strobe timing", strobe, es);
      if (es) seen++;
      chk(valid == (seen >= k + 1), "R6 valid timing", valid, (seen >= k + 1));
      if (es && pat == 0)
        chk(sample == 0, "R7 no history after restart", sample, 0);
      if (es && seen >= k + 1) begin
        case (pat)
          0: ex = 0;
          1: ex = full;
          2: ex = full / 2;
          default: ex = model(n);
        endcase
        chk(longint'(sample) == ex, tag, sample, ex);
      end
      start = 1'b0;
      case (pat)
        0: nb = 0;
        1: nb = 1;
        2: nb = (n + 1) & 1;
        default: nb = ($urandom_range(99) < dens) ? 1 : 0;
      endcase
      n++;
      if (n <= 1023) hist[n] = nb;
      bit_in = nb[0];
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end

  initial begin
    bit po3, o3, vs;
    int peff, preq, dens;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    // R10: outputs held at zero in and just after reset
    chk(sample == 0 && !strobe && !valid, "R10 reset state", {sample, strobe, valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sample == 0 && !strobe && !valid, "R10 release state", {sample, strobe, valid}, 0);
    repeat (3) @(negedge clk);

    run(0, 16, 0, 4, 1, 0, "R3 zeros");
    run(0, 16, 1, 4, 1, 0, "R4 order2 full scale");
    run(1, 16, 1, 5, 0, 0, "R4 order3 full scale");
    run(1, 16, 0, 5, 1, 0, "R7 zeros after ones");
    run(0, 64, 2, 4, 1, 0, "R3 half density order2");
    run(1, 100, 2, 5, 1, 0, "R3 half density order3");
    run(1, 511, 1, 5, 1, 0, "R9 modular wrap order3 max");
    run(1, 600, 1, 4, 1, 0, "R5 clamp order3");
    run(0, 0, 1, 4, 1, 0, "R5 zero request");
    run(0, 16383, 1, 3, 1, 0, "R5 clamp order2");
    run(0, 48, 1, 4, 0, 0, "R8 period change full scale");

    po3 = 0;
    peff = 48;
    for (int t = 0; t < 24; t++) begin
      o3 = 1'($urandom_range(1));
      preq = $urandom_range(40, 2);
      dens = $urandom_range(100);
      vs = 1'($urandom_range(1));
      if (o3 == po3 && preq == peff) vs = 1;
      run(o3, preq, 3, 6, vs, dens, "R2 weighted window sum");
      po3 = o3;
      peff = preq;
    end

    finish_run();
  end
endmodule